// File: doc/BRIEF.md
# Two-level masked interrupt combiner

The block gathers interrupt causes from two layers and drives a single active-low interrupt request toward a host. The upper layer is an 8-bit summary register. Three of its bits are sticky event flags for chip-wide conditions: an address clash, a target that cannot be reached, and a point-to-point link session ending. Four of its bits are not stored at all. Each one reports whether one of four per-channel ("socket") cause registers holds any set bit. Bit 4 of the summary register is unused.

A mask register with the same bit layout decides which summary bits may pull the request line low. A masked cause still shows in the summary register. The host reads all registers through a combinational read port and clears causes by writing ones. Clearing every bit of a socket register makes the matching summary bit fall with no further action. Event sources are single-cycle input pulses.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the mask register (0x16), the summary register (0x15) and all socket registers (0x20 + n) read 0x00, and `irq_n` is 1.
- R2: The mask register at address 0x16 is written with `wr_en`. Bit 7 enables the address-clash flag, bit 6 the unreachable flag, bit 5 the session-end flag, and bits 3..0 enable sockets 3..0. Bit 4 always reads 0.
- R3: `irq_n` is registered. It is 0 in the cycle after any cycle in which some summary bit and its mask bit are both 1, and it is 1 in the cycle after a cycle with no such pair.
- R4: A summary bit whose mask bit is 0 still reads as 1 at 0x15, but it alone does not drive `irq_n` low.
- R5: A 1 on `sock_evt[8*n+b]` sets bit b of socket register n (address 0x20 + n) at the next clock edge. Summary bit n reads 1 from then on.
- R6: Summary bit n reads 1 exactly while socket register n is nonzero. Writing ones to 0x20 + n clears those bits. The summary bit falls by itself once the register reaches 0x00.
- R7: `chip_evt[0]` sets summary bit 5, `chip_evt[1]` sets bit 6 and `chip_evt[2]` sets bit 7. Writing a 1 to bit 5, 6 or 7 at 0x15 clears that flag.
- R8: Writes to summary bits 4..0 at 0x15 have no effect.
- R9: When an event pulse and a write-one clear hit the same bit in the same cycle, the bit ends up set. This holds for both the chip flags and the socket registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chip_evt | input | 3 | Chip-level event pulses: [0] session end, [1] unreachable, [2] address clash |
| sock_evt | input | 32 | Socket event pulses, bits 8n+7..8n belong to socket n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data (write-one-to-clear for cause registers) |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data, 0 for unmapped addresses |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
On every cycle, embedded properties check four things: that a pulsed event is present in its cause register after the edge, which covers the case where a clear lands at the same time; that write-one clears take effect; that the request line follows the masked summary one cycle later; and that the reserved mask bit reads back as zero. Some behaviours can only be shown by the bench's scenarios comparing read data against a reference model. These are the self-clearing of a summary bit, which happens only after the last remaining socket bit is removed. They also include the fact that host writes to derived summary bits are ignored, and the visibility of masked causes under random mixes of events, mask changes and clears.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int NUM_SOCK  = 4;
  localparam int NUM_CHIP  = 3;
  localparam int CHIP_LSB  = 5;
  localparam int RSVD_BIT  = 4;
  localparam logic [ADDR_W-1:0] SUM_ADDR  = 8'h15;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 8'h16;
  localparam logic [ADDR_W-1:0] SOCK_BASE = 8'h20;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_w1c_reg.sv
module irq_w1c_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q,
  output logic         any_o
);
  logic [W-1:0] clr_mask;
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    clr_mask = wr_hit ? wr_data : '0;
    q_en     = wr_hit | (|set_i);
    q_nxt    = (q & ~clr_mask) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  assign any_o = |q;

  // R5 / R7 / R9: a pulsed bit is set after the edge, even under a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));

  // R6 / R7: write-one bits without a concurrent event are gone after the edge
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((q & $past(wr_data) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irq_mask_out.sv
module irq_mask_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cause,
  input  logic [W-1:0] enable,
  output logic         irq_n
);
  logic req_nxt;

  always_comb req_nxt = |(cause & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~req_nxt;
  end

  a_r3_irq_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause & enable)) |=> !irq_n);

  // R4: masked-only causes leave the request idle
  a_r4_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause & enable) == '0) |=> irq_n);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CHIP-1:0]          chip_evt,
  input  logic [NUM_SOCK*DATA_W-1:0]   sock_evt,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         irq_n
);
  localparam logic [DATA_W-1:0] MASK_WMASK = ~(DATA_W'(1) << RSVD_BIT);

  logic                 srst_n;
  logic [DATA_W-1:0]    mask_q;
  logic [DATA_W-1:0]    mask_nxt;
  logic                 mask_en;
  logic [NUM_CHIP-1:0]  chip_q;
  logic                 chip_any;
  logic                 sum_hit;
  logic [NUM_SOCK-1:0]  sock_nz;
  logic [DATA_W-1:0]    sock_q [NUM_SOCK];
  logic [DATA_W-1:0]    summary;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  // mask register: next-state and storage kept apart
  always_comb begin
    mask_en  = wr_en && (wr_addr == MASK_ADDR);
    mask_nxt = wr_data & MASK_WMASK;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_nxt;
  end

  // chip-level sticky flags map onto summary bits CHIP_LSB upward
  always_comb sum_hit = wr_en && (wr_addr == SUM_ADDR);

  irq_w1c_reg #(.W(NUM_CHIP)) u_chip (
    .clk(clk), .rst_n(srst_n), .set_i(chip_evt), .wr_hit(sum_hit),
    .wr_data(wr_data[CHIP_LSB +: NUM_CHIP]), .q(chip_q), .any_o(chip_any)
  );

  // per-socket cause registers
  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    logic hit;
    always_comb hit = wr_en && (wr_addr == SOCK_BASE + ADDR_W'(s));
    irq_w1c_reg #(.W(DATA_W)) u_sreg (
      .clk(clk), .rst_n(srst_n), .set_i(sock_evt[s*DATA_W +: DATA_W]),
      .wr_hit(hit), .wr_data(wr_data), .q(sock_q[s]), .any_o(sock_nz[s])
    );
  end

  always_comb begin
    summary                         = '0;
    summary[NUM_SOCK-1:0]           = sock_nz;
    summary[CHIP_LSB +: NUM_CHIP]   = chip_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == SUM_ADDR)       rd_data = summary;
    else if (rd_addr == MASK_ADDR) rd_data = mask_q;
    else begin
      for (int s = 0; s < NUM_SOCK; s++)
        if (rd_addr == SOCK_BASE + ADDR_W'(s)) rd_data = sock_q[s];
    end
  end

  irq_mask_out #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(srst_n), .cause(summary), .enable(mask_q), .irq_n(irq_n)
  );

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_addr == MASK_ADDR) |-> (rd_data[RSVD_BIT] == 1'b0));

  // R6: a socket summary bit never reads set once every socket register is clear
  a_r6_sum_follows: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_addr == SUM_ADDR && chip_any == 1'b0 && sock_nz == '0) |-> (rd_data == '0));
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  chip_evt;
  logic [31:0] sock_evt;
  logic        wr_en;
  logic [7:0]  wr_addr, wr_data, rd_addr;
  logic [7:0]  rd_data;
  logic        irq_n;

  int total = 0;
  int bad   = 0;

  logic [7:0] m_imr;
  logic [2:0] m_chip;
  logic [7:0] m_sock [4];
  logic       m_irq_n;

  always #2.5 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .chip_evt(chip_evt), .sock_evt(sock_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_sum();
    logic [7:0] v;
    v = {m_chip, 1'b0, 4'b0};
    for (int s = 0; s < 4; s++) v[s] = (m_sock[s] != 8'h00);
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'h15) return exp_sum();
    if (a == 8'h16) return m_imr;
    for (int s = 0; s < 4; s++) if (a == 8'h20 + 8'(s)) return m_sock[s];
    return 8'h00;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "irq_n", {7'd0, irq_n}, {7'd0, m_irq_n});
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h15 : (i == 1) ? 8'h16 : 8'h20 + 8'(i - 2);
      rd_addr = a;
      #0.2;
      check(tag, $sformatf("reg %h", a), rd_data, exp_read(a));
    end
  endtask

  task automatic cyc(input logic [2:0] ce, input logic [31:0] se,
                     input logic we, input logic [7:0] wa, input logic [7:0] wd);
    logic [7:0] sum_old;
    chip_evt = ce; sock_evt = se; wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    sum_old = exp_sum();
    m_irq_n = ~|(sum_old & m_imr);
    if (we && wa == 8'h16) m_imr = wd & 8'hEF;
    m_chip = (m_chip & ~((we && wa == 8'h15) ? wd[7:5] : 3'b0)) | ce;
    for (int s = 0; s < 4; s++)
      m_sock[s] = (m_sock[s] & ~((we && wa == 8'h20 + 8'(s)) ? wd : 8'h00))
                  | se[s*8 +: 8];
    @(negedge clk);
    chip_evt = '0; sock_evt = '0; wr_en = 1'b0;
    #0.5;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; chip_evt = '0; sock_evt = '0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    m_imr = '0; m_chip = '0; m_irq_n = 1'b1;
    for (int s = 0; s < 4; s++) m_sock[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #0.5;
    check_all("R1");

    cyc(3'b0, 32'h0, 1'b1, 8'h16, 8'hFF);
    check_all("R2");                           // reserved bit 4 reads 0

    cyc(3'b0, 32'h0000_0000 | (32'h0A << 16), 1'b0, 8'h00, 8'h00);
    check_all("R5");                           // socket 2 bits 1,3 set
    cyc(3'b0, 32'h0, 1'b0, 8'h00, 8'h00);
    check_all("R3");                           // irq low one clock later

    cyc(3'b0, 32'h0, 1'b1, 8'h15, 8'h1F);
    check_all("R8");                           // derived bits ignore writes
    cyc(3'b0, 32'h0, 1'b1, 8'h22, 8'h02);
    check_all("R6");                           // one bit left: still pending
    cyc(3'b0, 32'h0, 1'b1, 8'h22, 8'h08);
    check_all("R6");                           // register empty: bit drops
    cyc(3'b0, 32'h0, 1'b0, 8'h00, 8'h00);
    check_all("R3");                           // irq released

    cyc(3'b0, 32'h0, 1'b1, 8'h16, 8'h00);
    cyc(3'b110, 32'h0000_0001, 1'b0, 8'h00, 8'h00);
    cyc(3'b0, 32'h0, 1'b0, 8'h00, 8'h00);
    check_all("R4");                           // visible, masked

    cyc(3'b010, 32'h0, 1'b1, 8'h15, 8'hE0);
    check_all("R9");                           // chip event beats clear
    cyc(3'b0, 32'h0000_0001, 1'b1, 8'h20, 8'hFF);
    check_all("R9");                           // socket event beats clear
    cyc(3'b0, 32'h0, 1'b1, 8'h15, 8'hC0);
    check_all("R7");                           // clear flags 7 and 6

    for (int n = 0; n < 600; n++) begin
      logic [2:0]  ce;
      logic [31:0] se;
      logic        we;
      logic [7:0]  wa, wd;
      int          pick;
      ce = (($urandom % 6) == 0) ? 3'($urandom) : 3'b0;
      se = 32'h0;
      for (int b = 0; b < 32; b++) if (($urandom % 24) == 0) se[b] = 1'b1;
      we = (($urandom % 2) == 0);
      pick = int'($urandom % 7);
      wa = (pick == 0) ? 8'h15 : (pick == 1) ? 8'h16 :
           (pick == 6) ? 8'h30 : 8'h20 + 8'(pick - 2);
      wd = 8'($urandom);
      cyc(ce, se, we, wa, wd);
      check_all("R3 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule